// File: doc/BRIEF.md
# PWM Channel Output Router

This block sits between a bank of PWM channel generators and the output pins. Each channel supplies three raw waveforms (A, B, C) and two edge-shaped variants of A and B. Each channel has an A pin and a B pin, and each pin has a 4-bit mode input. The mode chooses which waveform drives that pin. A pin can take its own channel's signals, swap A and B, or borrow a signal from one of the next three channels. Channel indices wrap around the end of the bank.

Before any routing, each channel's signals are gated at their source. A per-channel fault input forces all five of that channel's signals low. Separate enable inputs for A and B force the plain and edge-shaped versions of that signal low. Because gating happens at the source, a pin that borrows a neighbour's waveform follows the neighbour's fault and enable state, not its own. Selection is combinational and feeds one output register per pin, so a pin shows the result one clock after its inputs were sampled.

Top module: `pwm_xbar`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `out_a` and `out_b` is 0 after that edge.
- R2: Each output bit is registered. The value after a rising edge is the routed value computed from the inputs sampled at that edge.
- R3: A-pin mode 0 selects the channel's own gated A, and B-pin mode 0 selects its own gated B. Mode values 9 to 15 behave exactly like mode 0.
- R4: Mode 1 selects the channel's own gated edge-shaped signal: edge A for the A pin, edge B for the B pin.
- R5: Mode 2 selects the channel's own gated C on either pin.
- R6: Mode 3 is a crossover: the A pin takes the channel's own gated B, and the B pin takes its own gated A.
- R7: Modes 4, 5 and 6 select gated A, B and C respectively of channel (n+1) mod 5, on either pin.
- R8: Mode 7 selects gated C of channel (n+2) mod 5, and mode 8 selects gated C of channel (n+3) mod 5. Channel 4 therefore reads channels 0, 1 and 2 for offsets 1, 2 and 3.
- R9: When `fault[k]` is high, every signal of channel k (A, B, C, edge A, edge B) reads as 0 at every pin that selects it, on any channel.
- R10: `en_a[k]` low forces channel k's A and edge A to 0, and `en_b[k]` low forces its B and edge B to 0, wherever they are routed. The enables do not affect C. A destination channel's own enables have no effect on a signal it borrows from another channel.
- R11: The B-pin mode list is the mirror of the A-pin list, and both pins of one channel are selected independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_a | input | NCH | Raw A waveform, bit k = channel k |
| raw_b | input | NCH | Raw B waveform per channel |
| raw_c | input | NCH | Raw C waveform per channel |
| edge_a | input | NCH | Edge-shaped A waveform per channel |
| edge_b | input | NCH | Edge-shaped B waveform per channel |
| fault | input | NCH | Per-channel fault; high blanks all of that channel's signals |
| en_a | input | NCH | Per-channel enable for A and edge A |
| en_b | input | NCH | Per-channel enable for B and edge B |
| mode_a | input | NCH*MODE_W | A-pin mode, field k at bits [k*MODE_W +: MODE_W] |
| mode_b | input | NCH*MODE_W | B-pin mode, field k at bits [k*MODE_W +: MODE_W] |
| out_a | output | NCH | Registered A pin per channel |
| out_b | output | NCH | Registered B pin per channel |

## Verification
The bench builds the block with its defaults, NCH = 5 and MODE_W = 4. At this size all sixteen mode codes can be swept on both pins of every channel. The sweep is repeated over many random patterns of waveforms, faults and enables. With five channels, every wrap offset from the last channels reaches across the bank boundary, so the modulo rule is exercised for n+1, n+2 and n+3. Directed cases set a fault or a cleared enable on one channel only, then observe both that channel's pins and the pins of the channels that borrow from it.

// File: rtl/pwm_xbar_pkg.sv
package pwm_xbar_pkg;

  typedef enum logic [3:0] {
    SRC_OWN   = 4'd0,
    SRC_EDGE  = 4'd1,
    SRC_OWN_C = 4'd2,
    SRC_CROSS = 4'd3,
    SRC_N1_A  = 4'd4,
    SRC_N1_B  = 4'd5,
    SRC_N1_C  = 4'd6,
    SRC_N2_C  = 4'd7,
    SRC_N3_C  = 4'd8
  } src_sel_e;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic ea;
    logic eb;
  } chan_sig_t;

  function automatic int nbr_idx(input int n, input int k, input int nch);
    return (n + k) % nch;
  endfunction

endpackage

// File: rtl/pwm_xbar_gate.sv
module pwm_xbar_gate
  import pwm_xbar_pkg::*;
(
  input  chan_sig_t raw,
  input  logic      fault,
  input  logic      en_a,
  input  logic      en_b,
  output chan_sig_t gated
);

  logic pass_a;
  logic pass_b;
  logic pass_c;

  always_comb begin
    pass_a = en_a & ~fault;
    pass_b = en_b & ~fault;
    pass_c = ~fault;
    gated.a  = raw.a  & pass_a;
    gated.ea = raw.ea & pass_a;
    gated.b  = raw.b  & pass_b;
    gated.eb = raw.eb & pass_b;
    gated.c  = raw.c  & pass_c;
  end

endmodule

// File: rtl/pwm_xbar_sel.sv
module pwm_xbar_sel
  import pwm_xbar_pkg::*;
#(
  parameter int  MODE_W = 4,
  parameter bit  IS_B   = 1'b0
) (
  input  chan_sig_t          own,
  input  chan_sig_t          nb1,
  input  chan_sig_t          nb2,
  input  chan_sig_t          nb3,
  input  logic [MODE_W-1:0]  mode,
  output logic               y
);

  logic self_sig;
  logic edge_sig;
  logic cross_sig;

  generate
    if (IS_B) begin : g_pin_b
      assign self_sig  = own.b;
      assign edge_sig  = own.eb;
      assign cross_sig = own.a;
    end else begin : g_pin_a
      assign self_sig  = own.a;
      assign edge_sig  = own.ea;
      assign cross_sig = own.b;
    end
  endgenerate

  always_comb begin
    y = self_sig;
    if (mode <= MODE_W'(8)) begin
      case (src_sel_e'(mode[3:0]))
        SRC_EDGE:  y = edge_sig;
        SRC_OWN_C: y = own.c;
        SRC_CROSS: y = cross_sig;
        SRC_N1_A:  y = nb1.a;
        SRC_N1_B:  y = nb1.b;
        SRC_N1_C:  y = nb1.c;
        SRC_N2_C:  y = nb2.c;
        SRC_N3_C:  y = nb3.c;
        default:   y = self_sig;
      endcase
    end
  end

endmodule

// File: rtl/pwm_xbar.sv
module pwm_xbar
  import pwm_xbar_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int MODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        raw_a,
  input  logic [NCH-1:0]        raw_b,
  input  logic [NCH-1:0]        raw_c,
  input  logic [NCH-1:0]        edge_a,
  input  logic [NCH-1:0]        edge_b,
  input  logic [NCH-1:0]        fault,
  input  logic [NCH-1:0]        en_a,
  input  logic [NCH-1:0]        en_b,
  input  logic [NCH*MODE_W-1:0] mode_a,
  input  logic [NCH*MODE_W-1:0] mode_b,
  output logic [NCH-1:0]        out_a,
  output logic [NCH-1:0]        out_b
);

  chan_sig_t gated [NCH];
  logic [NCH-1:0] nxt_a;
  logic [NCH-1:0] nxt_b;

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      localparam int N1 = nbr_idx(n, 1, NCH);
      localparam int N2 = nbr_idx(n, 2, NCH);
      localparam int N3 = nbr_idx(n, 3, NCH);

      chan_sig_t raw_n;
      assign raw_n = '{a: raw_a[n], b: raw_b[n], c: raw_c[n],
                       ea: edge_a[n], eb: edge_b[n]};

      pwm_xbar_gate u_gate (
        .raw   (raw_n),
        .fault (fault[n]),
        .en_a  (en_a[n]),
        .en_b  (en_b[n]),
        .gated (gated[n])
      );

      pwm_xbar_sel #(.MODE_W(MODE_W), .IS_B(1'b0)) u_sel_a (
        .own  (gated[n]),
        .nb1  (gated[N1]),
        .nb2  (gated[N2]),
        .nb3  (gated[N3]),
        .mode (mode_a[n*MODE_W +: MODE_W]),
        .y    (nxt_a[n])
      );

      pwm_xbar_sel #(.MODE_W(MODE_W), .IS_B(1'b1)) u_sel_b (
        .own  (gated[n]),
        .nb1  (gated[N1]),
        .nb2  (gated[N2]),
        .nb3  (gated[N3]),
        .mode (mode_b[n*MODE_W +: MODE_W]),
        .y    (nxt_b[n])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          out_a[n] <= 1'b0;
          out_b[n] <= 1'b0;
        end else begin
          out_a[n] <= nxt_a[n];
          out_b[n] <= nxt_b[n];
        end
      end

      AST_FAULT_BLANKS_OWN: assert property (@(posedge clk) disable iff (rst)
        (fault[n] && mode_a[n*MODE_W +: MODE_W] <= MODE_W'(3)) |=> !out_a[n]); // R9

      AST_ENA_CLEARS_OWN: assert property (@(posedge clk) disable iff (rst)
        (!en_a[n] && mode_a[n*MODE_W +: MODE_W] == MODE_W'(0)) |=> !out_a[n]); // R10

      AST_CROSS_B_TO_A: assert property (@(posedge clk) disable iff (rst)
        (mode_a[n*MODE_W +: MODE_W] == MODE_W'(3) && !fault[n] && en_b[n])
          |=> out_a[n] == $past(raw_b[n])); // R6

      AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
        (mode_b[n*MODE_W +: MODE_W] >= MODE_W'(9) && !fault[n] && en_b[n])
          |=> out_b[n] == $past(raw_b[n])); // R3

      AST_WRAP_N2_C: assert property (@(posedge clk) disable iff (rst)
        (mode_a[n*MODE_W +: MODE_W] == MODE_W'(7) && !fault[N2])
          |=> out_a[n] == $past(raw_c[N2])); // R8

      AST_N1_A_DEST_EN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mode_b[n*MODE_W +: MODE_W] == MODE_W'(4) && !fault[N1] && en_a[N1])
          |=> out_b[n] == $past(raw_a[N1])); // R10
    end
  endgenerate

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (out_a == '0 && out_b == '0)); // R1

endmodule

// File: tb/pwm_xbar_tb.sv
module pwm_xbar_tb;

  localparam int NCH    = 5;
  localparam int MODE_W = 4;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NCH-1:0]        raw_a, raw_b, raw_c, edge_a, edge_b;
  logic [NCH-1:0]        fault, en_a, en_b;
  logic [NCH*MODE_W-1:0] mode_a, mode_b;
  logic [NCH-1:0]        out_a, out_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pwm_xbar #(.NCH(NCH), .MODE_W(MODE_W)) u_dut (
    .clk(clk), .rst(rst),
    .raw_a(raw_a), .raw_b(raw_b), .raw_c(raw_c),
    .edge_a(edge_a), .edge_b(edge_b),
    .fault(fault), .en_a(en_a), .en_b(en_b),
    .mode_a(mode_a), .mode_b(mode_b),
    .out_a(out_a), .out_b(out_b)
  );

  function automatic logic gsig(input int k, input int which);
    logic ok_a, ok_b;
    ok_a = en_a[k] & ~fault[k];
    ok_b = en_b[k] & ~fault[k];
    case (which)
      0: return raw_a[k] & ok_a;
      1: return raw_b[k] & ok_b;
      2: return raw_c[k] & ~fault[k];
      3: return edge_a[k] & ok_a;
      default: return edge_b[k] & ok_b;
    endcase
  endfunction

  function automatic logic ref_pin(input int n, input int m, input bit pin_b);
    int selfw, edgew, crossw;
    selfw  = pin_b ? 1 : 0;
    edgew  = pin_b ? 4 : 3;
    crossw = pin_b ? 0 : 1;
    case (m)
      1: return gsig(n, edgew);
      2: return gsig(n, 2);
      3: return gsig(n, crossw);
      4: return gsig((n + 1) % NCH, 0);
      5: return gsig((n + 1) % NCH, 1);
      6: return gsig((n + 1) % NCH, 2);
      7: return gsig((n + 2) % NCH, 2);
      8: return gsig((n + 3) % NCH, 2);
      default: return gsig(n, selfw);
    endcase
  endfunction

  function automatic string req_of(input int m);
    if (m == 0 || m >= 9) return "R3";
    if (m == 1) return "R4";
    if (m == 2) return "R5";
    if (m == 3) return "R6";
    if (m <= 6) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_all_modes(input int ma, input int mb);
    for (int k = 0; k < NCH; k++) begin
      mode_a[k*MODE_W +: MODE_W] = MODE_W'(ma);
      mode_b[k*MODE_W +: MODE_W] = MODE_W'(mb);
    end
  endtask

  // Expected values are computed at drive time, before the sampling edge.
  task automatic step_and_check(input string extra);
    logic [NCH-1:0] ea, eb;
    int ma, mb;
    for (int k = 0; k < NCH; k++) begin
      ma = int'(mode_a[k*MODE_W +: MODE_W]);
      mb = int'(mode_b[k*MODE_W +: MODE_W]);
      ea[k] = ref_pin(k, ma, 1'b0);
      eb[k] = ref_pin(k, mb, 1'b1);
    end
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      ma = int'(mode_a[k*MODE_W +: MODE_W]);
      mb = int'(mode_b[k*MODE_W +: MODE_W]);
      check({req_of(ma), extra}, $sformatf("R2 ch%0d pin A mode %0d", k, ma), out_a[k], ea[k]);
      check({req_of(mb), extra, " R11"}, $sformatf("R2 ch%0d pin B mode %0d", k, mb), out_b[k], eb[k]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    raw_a = '1; raw_b = '1; raw_c = '1; edge_a = '1; edge_b = '1;
    fault = '0; en_a = '1; en_b = '1;
    set_all_modes(0, 0);
    @(negedge clk);
    @(negedge clk);
    // R1: reset holds outputs low despite all-ones sources
    for (int k = 0; k < NCH; k++) begin
      check("R1", $sformatf("reset ch%0d A", k), out_a[k], 1'b0);
      check("R1", $sformatf("reset ch%0d B", k), out_b[k], 1'b0);
    end
    rst = 1'b0;

    // Sweep: every mode on A, a rotated mode on B, random sources and gating
    for (int rep = 0; rep < 60; rep++) begin
      for (int m = 0; m < 16; m++) begin
        raw_a  = NCH'($urandom); raw_b  = NCH'($urandom); raw_c = NCH'($urandom);
        edge_a = NCH'($urandom); edge_b = NCH'($urandom);
        fault  = NCH'($urandom & $urandom);
        en_a   = NCH'($urandom | $urandom);
        en_b   = NCH'($urandom | $urandom);
        for (int k = 0; k < NCH; k++) begin
          mode_a[k*MODE_W +: MODE_W] = MODE_W'((m + k * rep) % 16);
          mode_b[k*MODE_W +: MODE_W] = MODE_W'((m + 7 + k) % 16);
        end
        step_and_check("");
      end
    end

    // R9: fault on channel 1 only; channel 0 borrows its C
    raw_a = '1; raw_b = '1; raw_c = '1; edge_a = '1; edge_b = '1;
    fault = 5'b00010; en_a = '1; en_b = '1;
    set_all_modes(6, 5);
    step_and_check(" R9");
    check("R9", "ch0 A borrows faulted ch1 C", out_a[0], 1'b0);
    check("R9", "ch2 A borrows healthy ch3 C", out_a[2], 1'b1);

    // R10: cleared A enable on channel 0 only; destination enable ignored
    fault = '0; en_a = 5'b11110;
    set_all_modes(4, 2);
    step_and_check(" R10");
    check("R10", "ch0 A borrows ch1 A despite own enable low", out_a[0], 1'b1);
    check("R10", "ch4 A borrows disabled ch0 A", out_a[4], 1'b0);
    check("R10", "ch0 B own C unaffected by enable", out_b[0], 1'b1);

    // R8: wrap from the last channel
    raw_c = 5'b00100; en_a = '1;
    set_all_modes(8, 7);
    step_and_check(" R8");
    check("R8", "ch4 A takes C of ch2", out_a[4], 1'b1);
    check("R8", "ch0 B takes C of ch2", out_b[0], 1'b1);

    // R1 again mid-run
    raw_a = '1; set_all_modes(0, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset mid-run A", |out_a, 1'b0);
    check("R1", "reset mid-run B", |out_b, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule